// File: doc/BRIEF.md
# Multi-Pass XOR Image Cipher Sequencer

This block walks a stored square image through between one and four successive XOR cipher passes and then hands the memory over to a display scanner. It is a Moore state machine that drives the pixel memory address and write strobe. It also drives the control pins of an external keystream generator: a one-cycle reload pulse, an advance strobe, and a pass selector. The pass selector picks both the generator's configuration and the key segment that seeds it. Each write cycle stores the pixel read in the previous cycle XORed with the current keystream word.

A single counter sequences the work. Its low bits address pixels and its top bits number the pass, so one increment per write both scans the image and steps from pass to pass. A one-bit flag records whether the stored image is encrypted. A request that already matches the flag goes straight to display, and a request that differs runs the passes and then inverts the flag. The keystream advances only on write cycles, so running the same request count with the same keys in the other direction regenerates the identical streams and restores the image.

Top module: `xor_pass_sequencer`

## Requirements
- R1: While and right after reset the block is idle: show_mode = 1, mem_we = 0, ks_init = 0, and img_enc holds the value of init_state sampled during reset (1 = encrypted).
- R2: A start pulse with enc_req (1 = encrypt, 0 = decrypt) equal to img_enc performs no write cycle and leaves img_enc unchanged.
- R3: During processing, read cycles (mem_we = 0) and write cycles (mem_we = 1) alternate; a write goes to the same address as the read just before it; within a pass, write addresses run 0, 1, ... up to 2^ADDR_W - 1.
- R4: In every write cycle wr_pixel equals rd_pixel XOR ks_word.
- R5: n_pass + 1 passes are run (n_pass = 0 gives one pass); pass_sel equals the pass number 0, 1, ... during that pass, and the final memory equals the image XORed with one keystream per pass.
- R6: ks_init is high for one cycle at the read of address 0 of each pass (n_pass + 1 pulses per operation), never in display mode; ks_step is high exactly in write cycles.
- R7: img_enc flips two cycles after the last write of an operation, with one non-writing cycle in between.
- R8: Whenever show_mode = 1, mem_addr equals disp_addr and mem_we = 0; show_mode is 0 throughout processing.
- R9: In display, start is ignored while enc_req equals img_enc; once enc_req differs, the block waits for start before any write.
- R10: An encrypt followed by a decrypt with the same n_pass and keys restores the original image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| enc_req | input | 1 | 1 = encrypt, 0 = decrypt |
| init_state | input | 1 | Image state loaded during reset (1 = encrypted) |
| n_pass | input | PASS_W | Number of passes minus one |
| rd_pixel | input | PIX_W | Pixel read from memory, valid the cycle after its address |
| ks_word | input | PIX_W | Current keystream word |
| disp_addr | input | ADDR_W | Address from the display scanner |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write strobe (1 = write) |
| wr_pixel | output | PIX_W | Pixel to write |
| ks_init | output | 1 | Reload the keystream generator from the selected key |
| ks_step | output | 1 | Advance the keystream generator |
| pass_sel | output | PASS_W | Generator configuration and key segment select |
| show_mode | output | 1 | 1 = display mode, memory address from disp_addr |
| img_enc | output | 1 | Stored image state (1 = encrypted) |

## Verification
The last write of one pass and the switch to the next pass fall on the same clock edge. A single counter increment moves the address from all ones to zero and raises pass_sel, and the read that follows must both pulse ks_init and present the new selector. The bench uses a tiny image so this boundary occurs many times per operation. At every write it compares the observed address and pass_sel against its own running write index, and it counts reload pulses against n_pass + 1. A misplaced reload or a selector that changes one cycle late also shows up in the final memory contents, which the bench compares against its own keystream model.

// File: rtl/xps_pkg.sv
package xps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_WR   = 3'd2,
        ST_ADJ  = 3'd3,
        ST_DISP = 3'd4
    } xps_state_e;

    typedef struct packed {
        logic mem_we;
        logic ks_step;
        logic show;
        logic rd_phase;
    } xps_strobe_t;

    function automatic xps_strobe_t decode_state(input xps_state_e st);
        xps_strobe_t s;
        s.mem_we   = (st == ST_WR);
        s.ks_step  = (st == ST_WR);
        s.rd_phase = (st == ST_RD);
        s.show     = (st == ST_IDLE) || (st == ST_ADJ) || (st == ST_DISP);
        return s;
    endfunction

endpackage

// File: rtl/xps_cnt.sv
module xps_cnt #(
    parameter int ADDR_W = 16,
    parameter int PASS_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] pix,
    output logic [PASS_W-1:0] pass,
    output logic              pix_first,
    output logic              pix_last
);
    localparam int CNT_W = ADDR_W + PASS_W;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pix       = cnt_q[ADDR_W-1:0];
    assign pass      = cnt_q[CNT_W-1:ADDR_W];
    assign pix_first = (pix == '0);
    assign pix_last  = &pix;
endmodule

// File: rtl/xps_ctrl.sv
module xps_ctrl
    import xps_pkg::*;
#(
    parameter int PASS_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              enc_req,
    input  logic              init_state,
    input  logic [PASS_W-1:0] n_pass,
    input  logic [PASS_W-1:0] pass,
    input  logic              pix_last,
    output xps_state_e        state,
    output logic              img_enc,
    output logic              cnt_inc
);
    xps_state_e nxt;
    logic       done;

    assign done    = (pass == n_pass) && pix_last;
    assign cnt_inc = (state == ST_WR) && !done;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = (enc_req == img_enc) ? ST_DISP : ST_RD;
            ST_RD:   nxt = ST_WR;
            ST_WR:   nxt = done ? ST_ADJ : ST_RD;
            ST_ADJ:  nxt = ST_DISP;
            ST_DISP: if (enc_req != img_enc) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            img_enc <= init_state;
        end else begin
            state <= nxt;
            if (state == ST_ADJ) begin
                img_enc <= !img_enc;
            end
        end
    end
endmodule

// File: rtl/xps_dp.sv
module xps_dp
    import xps_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PIX_W  = 24
) (
    input  xps_state_e        state,
    input  logic [ADDR_W-1:0] pix,
    input  logic              pix_first,
    input  logic [ADDR_W-1:0] disp_addr,
    input  logic [PIX_W-1:0]  rd_pixel,
    input  logic [PIX_W-1:0]  ks_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [PIX_W-1:0]  wr_pixel,
    output logic              ks_init,
    output logic              ks_step,
    output logic              show_mode
);
    xps_strobe_t strb;

    assign strb      = decode_state(state);
    assign mem_we    = strb.mem_we;
    assign ks_step   = strb.ks_step;
    assign show_mode = strb.show;
    assign ks_init   = strb.rd_phase && pix_first;
    assign mem_addr  = strb.show ? disp_addr : pix;
    assign wr_pixel  = rd_pixel ^ ks_word;
endmodule

// File: rtl/xor_pass_sequencer.sv
module xor_pass_sequencer
    import xps_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PASS_W = 2,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              enc_req,
    input  logic              init_state,
    input  logic [PASS_W-1:0] n_pass,
    input  logic [PIX_W-1:0]  rd_pixel,
    input  logic [PIX_W-1:0]  ks_word,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [PIX_W-1:0]  wr_pixel,
    output logic              ks_init,
    output logic              ks_step,
    output logic [PASS_W-1:0] pass_sel,
    output logic              show_mode,
    output logic              img_enc
);
    xps_state_e        state;
    logic [ADDR_W-1:0] pix;
    logic [PASS_W-1:0] pass;
    logic              pix_first;
    logic              pix_last;
    logic              cnt_inc;

    xps_cnt #(.ADDR_W(ADDR_W), .PASS_W(PASS_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (show_mode),
        .inc       (cnt_inc),
        .pix       (pix),
        .pass      (pass),
        .pix_first (pix_first),
        .pix_last  (pix_last)
    );

    xps_ctrl #(.PASS_W(PASS_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .enc_req    (enc_req),
        .init_state (init_state),
        .n_pass     (n_pass),
        .pass       (pass),
        .pix_last   (pix_last),
        .state      (state),
        .img_enc    (img_enc),
        .cnt_inc    (cnt_inc)
    );

    xps_dp #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_dp (
        .state     (state),
        .pix       (pix),
        .pix_first (pix_first),
        .disp_addr (disp_addr),
        .rd_pixel  (rd_pixel),
        .ks_word   (ks_word),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .wr_pixel  (wr_pixel),
        .ks_init   (ks_init),
        .ks_step   (ks_step),
        .show_mode (show_mode)
    );

    assign pass_sel = pass;
endmodule

// File: rtl/xps_chk.sv
module xps_chk #(
    parameter int ADDR_W = 16,
    parameter int PASS_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              ks_init,
    input logic              ks_step,
    input logic              show_mode,
    input logic              img_enc
);
    // R3
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R3
    wr_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (!$past(mem_we) && mem_addr == $past(mem_addr)));

    // R6
    init_single_chk: assert property (@(posedge clk) disable iff (rst)
        ks_init |=> !ks_init);

    // R6
    init_place_chk: assert property (@(posedge clk) disable iff (rst)
        ks_init |-> (!mem_we && !show_mode && mem_addr == '0));

    // R6
    step_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        ks_step |-> (mem_we && !show_mode));

    // R7
    flip_after_adjust_chk: assert property (@(posedge clk) disable iff (rst)
        (img_enc != $past(img_enc)) |-> ($past(show_mode) && !$past(mem_we)));

    // R8
    display_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        show_mode |-> !mem_we);
endmodule

bind xor_pass_sequencer xps_chk #(.ADDR_W(ADDR_W), .PASS_W(PASS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .ks_init   (ks_init),
    .ks_step   (ks_step),
    .show_mode (show_mode),
    .img_enc   (img_enc)
);

// File: tb/xor_pass_sequencer_bench.sv
module xor_pass_sequencer_bench;
    localparam int AW   = 3;
    localparam int PW   = 2;
    localparam int DW   = 24;
    localparam int NPIX = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, start = 1'b0, enc_req = 1'b0, init_state = 1'b0;
    logic [PW-1:0] n_pass = '0;
    logic [DW-1:0] rd_pixel = '0, ks_word;
    logic [AW-1:0] disp_addr = '0, mem_addr;
    logic          mem_we, ks_init, ks_step, show_mode, img_enc;
    logic [DW-1:0] wr_pixel;
    logic [PW-1:0] pass_sel;

    xor_pass_sequencer #(.ADDR_W(AW), .PASS_W(PW), .PIX_W(DW)) u_xor_pass_sequencer (
        .clk(clk), .rst(rst), .start(start), .enc_req(enc_req), .init_state(init_state),
        .n_pass(n_pass), .rd_pixel(rd_pixel), .ks_word(ks_word), .disp_addr(disp_addr),
        .mem_addr(mem_addr), .mem_we(mem_we), .wr_pixel(wr_pixel), .ks_init(ks_init),
        .ks_step(ks_step), .pass_sel(pass_sel), .show_mode(show_mode), .img_enc(img_enc)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_of(input logic [31:0] k);
        return (k ^ 32'h5bd1e995) | 32'h1;
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] s);
        logic [31:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // memory and keystream models
    logic [DW-1:0] ram [NPIX];
    logic [DW-1:0] orig[NPIX];
    logic [DW-1:0] cur [NPIX];
    logic [31:0]   keys[4];
    logic [31:0]   ks_st = 32'h1;
    logic          fill = 1'b0;
    assign ks_word = ks_st[DW-1:0];

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < NPIX; i++) ram[i] <= orig[i];
        end else begin
            rd_pixel <= ram[mem_addr];
            if (mem_we) ram[mem_addr] <= wr_pixel;
        end
        if (ks_init)      ks_st <= seed_of(keys[pass_sel]);
        else if (ks_step) ks_st <= adv(ks_st);
    end

    // monitor
    int   exp_idx = 0, init_cnt = 0, since_wr = 100;
    logic prev_we = 1'b0, prev_enc = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                chk(!prev_we && prev_addr == mem_addr, "R3 read-before-write", {31'd0, prev_we}, 0);
                chk(mem_addr == AW'(exp_idx % NPIX), "R3 address order", mem_addr, exp_idx % NPIX);
                chk(pass_sel == PW'(exp_idx / NPIX), "R5 pass select", pass_sel, exp_idx / NPIX);
                chk(wr_pixel == (rd_pixel ^ ks_word), "R4 xor", wr_pixel, rd_pixel ^ ks_word);
                exp_idx++;
                since_wr = 0;
            end else if (since_wr < 100) begin
                since_wr++;
            end
            chk(ks_step == mem_we, "R6 step", ks_step, mem_we);
            if (ks_init) begin
                init_cnt++;
                chk(mem_addr == '0 && !show_mode, "R6 init place", mem_addr, 0);
            end
            if (show_mode) chk(mem_addr == disp_addr && !mem_we, "R8 display", mem_addr, disp_addr);
            if (img_enc != prev_enc) chk(since_wr == 2, "R7 flip timing", since_wr, 2);
        end else begin
            since_wr = 100;
        end
        prev_we   = mem_we;
        prev_addr = mem_addr;
        prev_enc  = img_enc;
        disp_addr = AW'($urandom);
    end

    task automatic do_reset(input logic v);
        rst = 1'b1; init_state = v;
        repeat (3) @(negedge clk);
        chk(show_mode && !mem_we && !ks_init, "R1 idle in reset", {show_mode, mem_we, ks_init}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(show_mode && !mem_we && !ks_init, "R1 idle after reset", {show_mode, mem_we, ks_init}, 3'b100);
        chk(img_enc == v, "R1 image state", img_enc, v);
    endtask

    task automatic run_op(input logic enc, input int np);
        enc_req = enc; n_pass = PW'(np);
        repeat (2) @(negedge clk);
        exp_idx = 0; init_cnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (img_enc == enc && show_mode) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_passes(input int np);
        for (int p = 0; p <= np; p++) begin
            logic [31:0] s = seed_of(keys[p]);
            for (int a = 0; a < NPIX; a++) begin
                cur[a] = cur[a] ^ s[DW-1:0];
                s = adv(s);
            end
        end
    endtask

    task automatic cmp_mem(input string req);
        for (int a = 0; a < NPIX; a++) chk(ram[a] == cur[a], req, ram[a], cur[a]);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NPIX; i++) begin orig[i] = DW'($urandom); cur[i] = orig[i]; end
        for (int k = 0; k < 4; k++) keys[k] = $urandom;
        fill = 1'b1;
        do_reset(1'b0);
        fill = 1'b0;

        // R2: request equals stored state
        run_op(1'b0, 3);
        chk(exp_idx == 0, "R2 no writes", exp_idx, 0);
        chk(img_enc == 1'b0, "R2 state kept", img_enc, 0);

        // R9: start in display with matching request is ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        chk(exp_idx == 0 && show_mode, "R9 start ignored", exp_idx, 0);
        enc_req = 1'b1;
        repeat (8) @(negedge clk);
        chk(exp_idx == 0 && img_enc == 1'b0, "R9 waits for start", exp_idx, 0);

        // directed: single pass, then four passes, each encrypt/decrypt
        for (int d = 0; d < 2; d++) begin
            int np = (d == 0) ? 0 : 3;
            run_op(1'b1, np);
            expect_passes(np);
            chk(exp_idx == (np + 1) * NPIX, "R5 write count", exp_idx, (np + 1) * NPIX);
            chk(init_cnt == np + 1, "R6 reload count", init_cnt, np + 1);
            chk(img_enc == 1'b1, "R7 flipped to encrypted", img_enc, 1);
            cmp_mem("R5 ciphertext");
            run_op(1'b0, np);
            expect_passes(np);
            chk(img_enc == 1'b0, "R7 flipped to decrypted", img_enc, 0);
            cmp_mem("R10 restored");
        end

        // random operations
        for (int r = 0; r < 6; r++) begin
            int np = $urandom_range(0, 3);
            for (int k = 0; k < 4; k++) keys[k] = $urandom;
            run_op(1'b1, np);
            expect_passes(np);
            chk(init_cnt == np + 1, "R6 reload count", init_cnt, np + 1);
            cmp_mem("R5 ciphertext");
            run_op(1'b0, np);
            expect_passes(np);
            chk(exp_idx == (np + 1) * NPIX, "R5 write count", exp_idx, (np + 1) * NPIX);
            cmp_mem("R10 restored");
        end

        // R1/R2: reset into encrypted state, encrypt request skips
        do_reset(1'b1);
        run_op(1'b1, 2);
        chk(exp_idx == 0 && img_enc == 1'b1, "R2 encrypted skip", exp_idx, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule